// File: doc/BRIEF.md
# Same-Axis Interval Phase and Bit-Timing Discriminator

This block turns the stream of axis-crossing events from a phasor sign analyser into two decoupled synchronisation signals. When the received phasor swings back and forth across a single axis, the time between two consecutive crossings of that axis should be exactly one symbol. A carrier phase offset makes the swing lopsided, so two successive same-axis intervals differ. The block keeps the previous same-axis interval and subtracts it from the newest one. It gives the result a sign according to which axis system was crossed. It discards the result when the asymmetry is too large to be trusted.

The same crossing events also drive bit timing. The ideal sampling instant lies halfway through each same-axis interval. The block halves the interval count that arrives with each same-axis crossing and emits a one-cycle timing strobe that many clocks later. This path does not use the phase estimate, so carrier and clock recovery do not depend on each other. The interval count comes from an external gauge that clears at every crossing. With a symbol length of NT counts, the timing resolution is one symbol divided by NT.

Top module: `same_axis_phase_timing`

## Requirements
- R1: After reset, `perr_vld_o` and `tstb_o` are low, `perr_o` is zero, and no previous interval is held, so the first same-axis crossing yields no phase output.
- R2: `perr_vld_o` is high for exactly the cycle after a clock edge that samples `cross_i`=1 with `adj_i`=0, and only when a previous same-axis interval is held and the R4 limit is met. It is low in every other cycle.
- R3: The phase error uses N1, the held interval, and N2, the newly arriving `ivl_i`. It is N2−N1 when `sys_vw_i`=1 (v/w axis system) and N1−N2 when `sys_vw_i`=0 (x/y system), in (CW+1)-bit two's complement. Each accepted same-axis crossing makes N2 the held interval.
- R4: A phase output is produced only when |N2−N1| is strictly less than 2·`sym_len_i`. Otherwise the output is suppressed, but N2 is still stored.
- R5: A crossing with `adj_i`=1 produces no phase output and discards the held interval. The next same-axis crossing after it therefore produces no phase output either.
- R6: A same-axis crossing sampled at edge E with count N makes `tstb_o` high for one cycle, starting at edge E+floor(N/2). For N<2 this is the cycle right after the crossing. Adjacent crossings do not start, stop or shift a strobe.
- R7: A same-axis crossing that arrives while a strobe is pending cancels that strobe, even if it lands on the very edge where the strobe would have fired. It then schedules a new strobe from its own count.
- R8: The timing strobe is scheduled whether or not a phase output is produced for that crossing, for example the first crossing after reset or after an adjacent crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the interval gauge |
| rst_n | input | 1 | Active-low synchronous reset |
| cross_i | input | 1 | One-cycle pulse marking an axis crossing |
| adj_i | input | 1 | With `cross_i`: 1 means an axis adjacent to the last one was crossed, 0 means the same axis |
| sys_vw_i | input | 1 | With `cross_i`: 1 means the crossed axis is in the v/w system, 0 means x/y |
| ivl_i | input | CW | Interval count since the previous crossing, valid with `cross_i` |
| sym_len_i | input | CW | Counts per symbol (NT) |
| perr_o | output | CW+1 | Signed phase error, held between outputs |
| perr_vld_o | output | 1 | One-cycle strobe qualifying `perr_o` |
| tstb_o | output | 1 | One-cycle bit-timing strobe |

## Verification
The phase output and the midpoint strobe's cancel-and-reload can both be triggered by the same same-axis crossing. The hardest case is a crossing that lands exactly on the edge where the pending strobe was due. The bench schedules a strobe from a long interval and then places a short-interval crossing on that edge. It checks three things: the old strobe never appears, the new phase error shows up the following cycle with the expected sign, and the new strobe fires at half the short count. Sweeps over pairs of intervals and over single intervals cover the threshold edge and every strobe delay.

// File: rtl/same_axis_phase_timing.sv
module same_axis_phase_timing #(
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cross_i,
  input  logic                 adj_i,
  input  logic                 sys_vw_i,
  input  logic [CW-1:0]        ivl_i,
  input  logic [CW-1:0]        sym_len_i,
  output logic signed [CW:0]   perr_o,
  output logic                 perr_vld_o,
  output logic                 tstb_o
);

  logic [CW-1:0] prev_q;
  logic          prev_vld_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q;

  wire           acc   = cross_i & ~adj_i;
  wire  [CW:0]   dlt   = {1'b0, ivl_i} - {1'b0, prev_q};
  wire  [CW:0]   mag   = dlt[CW] ? (~dlt + 1'b1) : dlt;
  wire  [CW:0]   nth   = {sym_len_i, 1'b0};
  wire           emit  = acc & prev_vld_q & (mag < nth);
  wire  [CW-1:0] half  = ivl_i >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
      perr_o     <= '0;
      perr_vld_o <= 1'b0;
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      tstb_o     <= 1'b0;
    end else begin
      perr_vld_o <= emit;
      if (emit) perr_o <= sys_vw_i ? dlt : (~dlt + 1'b1);
      if (cross_i) begin
        prev_q     <= ivl_i;
        prev_vld_q <= ~adj_i;
      end
      tstb_o <= 1'b0;
      if (acc) begin
        if (half == '0) begin
          tstb_o  <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          cnt_q   <= half;
          armed_q <= 1'b1;
        end
      end else if (armed_q) begin
        if (cnt_q == 1) begin
          tstb_o  <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/same_axis_phase_timing_chk.sv
module same_axis_phase_timing_chk #(
  parameter int CW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cross_i,
  input logic               adj_i,
  input logic [CW-1:0]      ivl_i,
  input logic [CW-1:0]      sym_len_i,
  input logic signed [CW:0] perr_o,
  input logic               perr_vld_o,
  input logic               tstb_o
);

  logic [CW:0] omag;
  assign omag = perr_o[CW] ? (~perr_o + 1'b1) : perr_o;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!perr_vld_o && !tstb_o));

  assert_vld_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    perr_vld_o |-> $past(cross_i && !adj_i));

  assert_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    perr_vld_o |-> (omag < {$past(sym_len_i), 1'b0}));

  assert_adj_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cross_i && adj_i) |=> !perr_vld_o);

  assert_short_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cross_i && !adj_i && ivl_i < 2) |=> tstb_o);

endmodule

bind same_axis_phase_timing same_axis_phase_timing_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cross_i(cross_i), .adj_i(adj_i),
  .ivl_i(ivl_i), .sym_len_i(sym_len_i), .perr_o(perr_o),
  .perr_vld_o(perr_vld_o), .tstb_o(tstb_o)
);

// File: tb/test_same_axis_phase_timing.sv
module test_same_axis_phase_timing;
  localparam int CW  = 8;
  localparam int PER = 10;
  localparam int NT  = 8;

  logic clk = 0, rst_n = 0, cross_i = 0, adj_i = 0, sys_vw_i = 0;
  logic [CW-1:0] ivl_i = '0, sym_len_i = NT[CW-1:0];
  logic signed [CW:0] perr_o;
  logic perr_vld_o, tstb_o;

  int n_chk = 0, n_bad = 0;
  int b_prev = 0;
  bit b_has = 0;

  always #(PER/2) clk = ~clk;

  same_axis_phase_timing #(.CW(CW)) i_same_axis_phase_timing (
    .clk(clk), .rst_n(rst_n), .cross_i(cross_i), .adj_i(adj_i),
    .sys_vw_i(sys_vw_i), .ivl_i(ivl_i), .sym_len_i(sym_len_i),
    .perr_o(perr_o), .perr_vld_o(perr_vld_o), .tstb_o(tstb_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one crossing; returns after the negedge following the capturing edge
  task automatic xing(input bit adj, input bit vw, input int n);
    int d, ep;
    bit ev;
    cross_i = 1; adj_i = adj; sys_vw_i = vw; ivl_i = n[CW-1:0];
    d  = n - b_prev;
    ev = !adj && b_has && ((d < 0 ? -d : d) < 2*NT);
    ep = vw ? d : -d;
    @(negedge clk);
    cross_i = 0; adj_i = 0;
    chk(perr_vld_o == ev, adj ? "R5" : "R2", perr_vld_o, ev);
    if (ev) chk(int'(perr_o) == ep, "R3", int'(perr_o), ep);
    b_has = !adj; b_prev = n;
  endtask

  // same-axis crossing, then trace the strobe until it must be over
  task automatic strobe_run(input int n, input string req);
    int h, hit;
    bit ok;
    h = n / 2; hit = -1; ok = 1;
    xing(0, 1, n);
    if (tstb_o) hit = 0;
    for (int k = 1; k <= h + 2; k++) begin
      @(negedge clk);
      if (tstb_o) begin
        if (hit >= 0) ok = 0;
        hit = k;
      end
    end
    chk(ok && hit == h, req, hit, h);
  endtask

  initial begin
    #(PER*150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!perr_vld_o && !tstb_o, "R1", {perr_vld_o, tstb_o}, 0);
    chk(int'(perr_o) == 0, "R1", int'(perr_o), 0);
    xing(0, 1, 9);   // first crossing: nothing held (R1)
    repeat (8) @(negedge clk);

    // R3 R4 sweep over interval pairs, both axis systems
    for (int vw = 0; vw < 2; vw++)
      for (int a = 0; a <= 20; a++)
        for (int b = 0; b <= 20; b++) begin
          xing(1, vw[0], 0);
          xing(0, vw[0], a);
          xing(0, vw[0], b);
        end
    repeat (12) @(negedge clk);

    // R5: adjacent crossing discards held interval
    xing(0, 1, 10);
    xing(1, 1, 12);
    xing(0, 1, 12);
    repeat (8) @(negedge clk);

    // R6 sweep of strobe delays; R8: first after adjacent has no phase output
    for (int n = 0; n <= 40; n++) begin
      xing(1, 0, 3);
      strobe_run(n, "R6_R8");
    end

    // R7: reload on the exact edge where the old strobe was due
    begin
      bit ok;
      int hit;
      ok = 1; hit = -1;
      xing(0, 1, 20);
      for (int k = 1; k <= 9; k++) begin
        @(negedge clk);
        if (tstb_o) ok = 0;
      end
      xing(0, 1, 6);   // phase -14 and cancel in same cycle
      if (tstb_o) ok = 0;
      for (int k = 1; k <= 5; k++) begin
        @(negedge clk);
        if (tstb_o) begin
          if (hit >= 0) ok = 0;
          hit = k;
        end
      end
      chk(ok && hit == 3, "R7", hit, 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule